// File: doc/BRIEF.md
# Port Default VLAN Tag Processor

This block assigns an effective 802.1Q tag to every frame that enters or leaves one of three switch ports. It works on header fields that a parser has already extracted, not on the byte stream. On the ingress side a request carries the port index, a tagged flag, the frame's VID and its priority. The block answers with the VID and priority that address lookup should use. Frames without a tag, and frames whose tag holds the null VID, get the port's default VID.

On the egress side a request carries the port index and a flag that says whether the port's tagging policy wants a tag inserted. The block answers with the 16-bit tag control field to insert, which is taken from the same per-port default tag.

Each port keeps its default tag in a pair of byte-wide registers that a host writes. Both request paths return their result one cycle after the request. A request sees the tag value that stood when the request was sampled, so a write that arrives in the same cycle affects only later frames.

Top module: `vlan_tag_proc`

## Requirements
- R1: After reset the default tag of every port is 0x0001: priority 0, CFI 0, VID 1.
- R2: The tag layout is [15:13] priority, [12] CFI, [11:0] VID. A write with `reg_hi_i`=1 replaces tag bits [15:8], and a write with `reg_hi_i`=0 replaces bits [7:0]. The other byte is left unchanged.
- R3: An untagged ingress frame (`ig_tagged_i`=0) gets the port's default VID and the default priority.
- R4: A tagged ingress frame with VID 0x000 gets the port's default VID and keeps its own priority.
- R5: A tagged ingress frame with a non-zero VID keeps its own VID and its own priority.
- R6: An egress request with `eg_insert_i`=1 returns `eg_insert_o`=1 and `eg_tci_o` equal to the port's full 16-bit default tag.
- R7: An egress request with `eg_insert_i`=0 returns `eg_insert_o`=0 and `eg_tci_o`=0.
- R8: `ig_valid_o` and `eg_valid_o` are high exactly in the cycle after a valid request to a legal port, and low in every other cycle.
- R9: A register write changes only the addressed port's tag.
- R10: A port index of `NUM_PORTS` or higher (3 by default) is ignored on all three interfaces. Such a request produces no valid output, and such a write changes no tag.
- R11: A request sampled in the same cycle as a write to its port uses the tag value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_port_i | input | 2 | Port index for the write |
| reg_hi_i | input | 1 | 1: write the upper tag byte, 0: write the lower tag byte |
| reg_wdata_i | input | 8 | Write data |
| ig_valid_i | input | 1 | Ingress request (start of frame) |
| ig_port_i | input | 2 | Ingress port index |
| ig_tagged_i | input | 1 | Frame carries an 802.1Q tag |
| ig_vid_i | input | 12 | VID parsed from the frame |
| ig_prio_i | input | 3 | Priority parsed from the frame |
| ig_valid_o | output | 1 | Ingress result valid |
| ig_vid_o | output | 12 | Effective VID for lookup |
| ig_prio_o | output | 3 | Effective priority |
| eg_valid_i | input | 1 | Egress request |
| eg_port_i | input | 2 | Egress port index |
| eg_insert_i | input | 1 | Tagging policy wants a tag inserted |
| eg_valid_o | output | 1 | Egress result valid |
| eg_insert_o | output | 1 | Insert the tag |
| eg_tci_o | output | 16 | Tag control field to insert |

## Verification
The properties assume that the request inputs are stable and known at each sampling edge. They also assume that a parser never presents `ig_vid_i` or `ig_prio_i` as X while `ig_valid_i` is high. The bench drives every input on the falling edge and returns strobes to zero one cycle later. Illegal port indices appear only where the bench intends them, to check that they are ignored. The VID checks compare the output with the inputs of the previous cycle, and they take for granted that no second request overlaps that window in a way the bench does not model. For that reason the bench sends at most one request per path per cycle.

// File: rtl/vtp_pkg.sv
package vtp_pkg;
  localparam int BYTE_W = 8;
  localparam int VID_W  = 12;
  localparam int PRIO_W = 3;
  localparam int TCI_W  = PRIO_W + 1 + VID_W;

  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic              cfi;
    logic [VID_W-1:0]  vid;
  } tci_t;

  localparam tci_t TCI_RST = '{prio: '0, cfi: 1'b0, vid: VID_W'(1)};
  localparam logic [VID_W-1:0] VID_NULL = '0;
endpackage

// File: rtl/vtp_tag_regs.sv
module vtp_tag_regs
  import vtp_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int PIDX_W    = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_i,
  input  logic [PIDX_W-1:0]           wr_port_i,
  input  logic                        wr_hi_i,
  input  logic [BYTE_W-1:0]           wr_data_i,
  output logic [NUM_PORTS-1:0][TCI_W-1:0] tags_o
);
  localparam int LO_W = BYTE_W;
  localparam int HI_W = TCI_W - BYTE_W;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic hit;
    logic [HI_W-1:0] hi_q;
    logic [LO_W-1:0] lo_q;
    localparam logic [TCI_W-1:0] RST_V = TCI_RST;

    assign hit = wr_i && (wr_port_i == PIDX_W'(p));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hi_q <= RST_V[TCI_W-1:LO_W];
        lo_q <= RST_V[LO_W-1:0];
      end else if (hit) begin
        if (wr_hi_i) hi_q <= wr_data_i[HI_W-1:0];
        else         lo_q <= wr_data_i;
      end
    end

    assign tags_o[p] = {hi_q, lo_q};
  end
endmodule

// File: rtl/vtp_port_mux.sv
module vtp_port_mux
  import vtp_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int PIDX_W    = 2
) (
  input  logic [PIDX_W-1:0]               port_i,
  input  logic [NUM_PORTS-1:0][TCI_W-1:0] tags_i,
  output logic                            legal_o,
  output tci_t                            tag_o
);
  always_comb begin
    legal_o = 1'b0;
    tag_o   = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (port_i == PIDX_W'(p)) begin
        legal_o = 1'b1;
        tag_o   = tci_t'(tags_i[p]);
      end
    end
  end
endmodule

// File: rtl/vtp_ingress.sv
module vtp_ingress
  import vtp_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int PIDX_W    = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            valid_i,
  input  logic [PIDX_W-1:0]               port_i,
  input  logic                            tagged_i,
  input  logic [VID_W-1:0]                vid_i,
  input  logic [PRIO_W-1:0]               prio_i,
  input  logic [NUM_PORTS-1:0][TCI_W-1:0] tags_i,
  output logic                            valid_o,
  output logic [VID_W-1:0]                vid_o,
  output logic [PRIO_W-1:0]               prio_o
);
  logic legal;
  tci_t dflt;
  logic [VID_W-1:0]  vid_d;
  logic [PRIO_W-1:0] prio_d;

  vtp_port_mux #(.NUM_PORTS(NUM_PORTS), .PIDX_W(PIDX_W)) u_mux (
    .port_i (port_i),
    .tags_i (tags_i),
    .legal_o(legal),
    .tag_o  (dflt)
  );

  // null VID in a tag is treated as untagged for VID, frame prio kept
  always_comb begin
    if (!tagged_i) begin
      vid_d  = dflt.vid;
      prio_d = dflt.prio;
    end else if (vid_i == VID_NULL) begin
      vid_d  = dflt.vid;
      prio_d = prio_i;
    end else begin
      vid_d  = vid_i;
      prio_d = prio_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      vid_o   <= '0;
      prio_o  <= '0;
    end else begin
      valid_o <= valid_i && legal;
      if (valid_i && legal) begin
        vid_o  <= vid_d;
        prio_o <= prio_d;
      end
    end
  end
endmodule

// File: rtl/vtp_egress.sv
module vtp_egress
  import vtp_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int PIDX_W    = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            valid_i,
  input  logic [PIDX_W-1:0]               port_i,
  input  logic                            insert_i,
  input  logic [NUM_PORTS-1:0][TCI_W-1:0] tags_i,
  output logic                            valid_o,
  output logic                            insert_o,
  output logic [TCI_W-1:0]                tci_o
);
  logic legal;
  tci_t dflt;

  vtp_port_mux #(.NUM_PORTS(NUM_PORTS), .PIDX_W(PIDX_W)) u_mux (
    .port_i (port_i),
    .tags_i (tags_i),
    .legal_o(legal),
    .tag_o  (dflt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      insert_o <= 1'b0;
      tci_o    <= '0;
    end else begin
      valid_o <= valid_i && legal;
      if (valid_i && legal) begin
        insert_o <= insert_i;
        tci_o    <= insert_i ? TCI_W'(dflt) : '0;
      end
    end
  end
endmodule

// File: rtl/vlan_tag_proc.sv
module vlan_tag_proc
  import vtp_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int PIDX_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [PIDX_W-1:0] reg_port_i,
  input  logic              reg_hi_i,
  input  logic [7:0]        reg_wdata_i,
  input  logic              ig_valid_i,
  input  logic [PIDX_W-1:0] ig_port_i,
  input  logic              ig_tagged_i,
  input  logic [11:0]       ig_vid_i,
  input  logic [2:0]        ig_prio_i,
  output logic              ig_valid_o,
  output logic [11:0]       ig_vid_o,
  output logic [2:0]        ig_prio_o,
  input  logic              eg_valid_i,
  input  logic [PIDX_W-1:0] eg_port_i,
  input  logic              eg_insert_i,
  output logic              eg_valid_o,
  output logic              eg_insert_o,
  output logic [15:0]       eg_tci_o
);
  logic [NUM_PORTS-1:0][TCI_W-1:0] tags;

  vtp_tag_regs #(.NUM_PORTS(NUM_PORTS), .PIDX_W(PIDX_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (reg_wr_i),
    .wr_port_i(reg_port_i),
    .wr_hi_i  (reg_hi_i),
    .wr_data_i(reg_wdata_i),
    .tags_o   (tags)
  );

  vtp_ingress #(.NUM_PORTS(NUM_PORTS), .PIDX_W(PIDX_W)) u_ig (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (ig_valid_i),
    .port_i  (ig_port_i),
    .tagged_i(ig_tagged_i),
    .vid_i   (ig_vid_i),
    .prio_i  (ig_prio_i),
    .tags_i  (tags),
    .valid_o (ig_valid_o),
    .vid_o   (ig_vid_o),
    .prio_o  (ig_prio_o)
  );

  vtp_egress #(.NUM_PORTS(NUM_PORTS), .PIDX_W(PIDX_W)) u_eg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (eg_valid_i),
    .port_i  (eg_port_i),
    .insert_i(eg_insert_i),
    .tags_i  (tags),
    .valid_o (eg_valid_o),
    .insert_o(eg_insert_o),
    .tci_o   (eg_tci_o)
  );
endmodule

// File: rtl/vtp_checker.sv
module vtp_checker #(
  parameter int NUM_PORTS = 3,
  parameter int PIDX_W    = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [PIDX_W-1:0] reg_port_i,
  input logic              reg_hi_i,
  input logic [7:0]        reg_wdata_i,
  input logic              ig_valid_i,
  input logic [PIDX_W-1:0] ig_port_i,
  input logic              ig_tagged_i,
  input logic [11:0]       ig_vid_i,
  input logic [2:0]        ig_prio_i,
  input logic              ig_valid_o,
  input logic [11:0]       ig_vid_o,
  input logic [2:0]        ig_prio_o,
  input logic              eg_valid_i,
  input logic [PIDX_W-1:0] eg_port_i,
  input logic              eg_insert_i,
  input logic              eg_valid_o,
  input logic              eg_insert_o,
  input logic [15:0]       eg_tci_o
);
  localparam logic [PIDX_W:0] LIM = (PIDX_W+1)'(NUM_PORTS);
  logic ig_ok, eg_ok;
  assign ig_ok = ig_valid_i && ({1'b0, ig_port_i} < LIM);
  assign eg_ok = eg_valid_i && ({1'b0, eg_port_i} < LIM);

  p_ig_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ig_ok |=> ig_valid_o);
  p_ig_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ig_ok |=> !ig_valid_o);
  p_eg_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eg_ok |=> !eg_valid_o);
  p_own_tag_kept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ig_ok && ig_tagged_i && ig_vid_i != 12'd0)
      |=> (ig_vid_o == $past(ig_vid_i)) && (ig_prio_o == $past(ig_prio_i)));
  p_null_vid_prio_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ig_ok && ig_tagged_i && ig_vid_i == 12'd0) |=> ig_prio_o == $past(ig_prio_i));
  p_no_insert_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eg_ok && !eg_insert_i) |=> (!eg_insert_o && eg_tci_o == 16'h0000));
endmodule

bind vlan_tag_proc vtp_checker #(.NUM_PORTS(NUM_PORTS), .PIDX_W(PIDX_W)) u_chk (.*);

// File: tb/vlan_tag_proc_bench.sv
`timescale 1ns/1ps
module vlan_tag_proc_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        reg_wr = 0, reg_hi = 0;
  logic [1:0]  reg_port = 0;
  logic [7:0]  reg_wdata = 0;
  logic        ig_valid = 0, ig_tagged = 0;
  logic [1:0]  ig_port = 0;
  logic [11:0] ig_vid = 0;
  logic [2:0]  ig_prio = 0;
  logic        ig_valid_o;
  logic [11:0] ig_vid_o;
  logic [2:0]  ig_prio_o;
  logic        eg_valid = 0, eg_insert = 0;
  logic [1:0]  eg_port = 0;
  logic        eg_valid_o, eg_insert_o;
  logic [15:0] eg_tci_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_tag [3];

  vlan_tag_proc u_vlan_tag_proc (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_port_i(reg_port), .reg_hi_i(reg_hi), .reg_wdata_i(reg_wdata),
    .ig_valid_i(ig_valid), .ig_port_i(ig_port), .ig_tagged_i(ig_tagged),
    .ig_vid_i(ig_vid), .ig_prio_i(ig_prio),
    .ig_valid_o(ig_valid_o), .ig_vid_o(ig_vid_o), .ig_prio_o(ig_prio_o),
    .eg_valid_i(eg_valid), .eg_port_i(eg_port), .eg_insert_i(eg_insert),
    .eg_valid_o(eg_valid_o), .eg_insert_o(eg_insert_o), .eg_tci_o(eg_tci_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] p, input bit hi, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_port = p; reg_hi = hi; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    if (p < 3) begin
      if (hi) exp_tag[p][15:8] = d; else exp_tag[p][7:0] = d;
    end
  endtask

  task automatic do_ig(input logic [1:0] p, input bit tg, input logic [11:0] v, input logic [2:0] pr);
    @(negedge clk);
    ig_valid = 1; ig_port = p; ig_tagged = tg; ig_vid = v; ig_prio = pr;
    @(negedge clk);
    ig_valid = 0;
  endtask

  task automatic do_eg(input logic [1:0] p, input bit ins);
    @(negedge clk);
    eg_valid = 1; eg_port = p; eg_insert = ins;
    @(negedge clk);
    eg_valid = 0;
  endtask

  task automatic t_reset();
    chk(!ig_valid_o && !eg_valid_o, "R8 reset outputs idle", {ig_valid_o, eg_valid_o}, 0);
    for (int p = 0; p < 3; p++) begin
      do_eg(2'(p), 1);
      chk(eg_valid_o && eg_tci_o == 16'h0001, "R1 reset tag", eg_tci_o, 16'h0001);
    end
  endtask

  task automatic t_layout();
    do_write(0, 1, 8'hB5);
    do_eg(0, 1);
    chk(eg_tci_o == 16'hB501, "R2 upper byte only", eg_tci_o, 16'hB501);
    do_write(0, 0, 8'h3C);
    do_eg(0, 1);
    chk(eg_tci_o == 16'hB53C, "R2 lower byte only", eg_tci_o, 16'hB53C);
    chk(eg_insert_o, "R6 insert flag", eg_insert_o, 1);
  endtask

  task automatic t_untagged();
    // port0 tag 0xB53C: prio 5, VID 0x53C
    do_ig(0, 0, 12'h777, 3'd2);
    chk(ig_valid_o && ig_vid_o == 12'h53C, "R3 untagged VID", ig_vid_o, 12'h53C);
    chk(ig_prio_o == 3'd5, "R3 untagged prio", ig_prio_o, 5);
  endtask

  task automatic t_null_vid();
    do_ig(0, 1, 12'h000, 3'd6);
    chk(ig_vid_o == 12'h53C, "R4 null VID gets default", ig_vid_o, 12'h53C);
    chk(ig_prio_o == 3'd6, "R4 null VID keeps prio", ig_prio_o, 6);
  endtask

  task automatic t_tagged();
    do_ig(0, 1, 12'hABC, 3'd1);
    chk(ig_vid_o == 12'hABC && ig_prio_o == 3'd1, "R5 own tag kept", {ig_vid_o, ig_prio_o}, {12'hABC, 3'd1});
    do_ig(1, 1, 12'hFFF, 3'd7);
    chk(ig_vid_o == 12'hFFF && ig_prio_o == 3'd7, "R5 max VID kept", {ig_vid_o, ig_prio_o}, {12'hFFF, 3'd7});
  endtask

  task automatic t_no_insert();
    do_eg(0, 0);
    chk(eg_valid_o && !eg_insert_o && eg_tci_o == 16'h0, "R7 no insert", eg_tci_o, 0);
  endtask

  task automatic t_latency();
    do_ig(2, 0, 0, 0);
    chk(ig_valid_o, "R8 ingress valid after one cycle", ig_valid_o, 1);
    @(negedge clk);
    chk(!ig_valid_o, "R8 ingress valid single cycle", ig_valid_o, 0);
    do_eg(2, 1);
    chk(eg_valid_o, "R8 egress valid after one cycle", eg_valid_o, 1);
    @(negedge clk);
    chk(!eg_valid_o, "R8 egress valid single cycle", eg_valid_o, 0);
  endtask

  task automatic t_port_indep();
    do_write(1, 1, 8'h2F);
    do_write(1, 0, 8'hEE);
    for (int p = 0; p < 3; p++) begin
      do_eg(2'(p), 1);
      chk(eg_tci_o == exp_tag[p], "R9 per-port tag", eg_tci_o, exp_tag[p]);
    end
    do_ig(2, 0, 12'h123, 3'd4);
    chk(ig_vid_o == 12'h001 && ig_prio_o == 3'd0, "R9 port2 untouched", {ig_vid_o, ig_prio_o}, {12'h001, 3'd0});
  endtask

  task automatic t_bad_port();
    do_write(3, 1, 8'hFF);
    do_write(3, 0, 8'hFF);
    for (int p = 0; p < 3; p++) begin
      do_eg(2'(p), 1);
      chk(eg_tci_o == exp_tag[p], "R10 write to port 3 ignored", eg_tci_o, exp_tag[p]);
    end
    do_ig(3, 0, 12'h5, 3'd1);
    chk(!ig_valid_o, "R10 ingress port 3 no result", ig_valid_o, 0);
    do_eg(3, 1);
    chk(!eg_valid_o, "R10 egress port 3 no result", eg_valid_o, 0);
  endtask

  task automatic t_same_cycle();
    // port2 tag 0x0001; write upper=0xE0 in the request cycle
    @(negedge clk);
    reg_wr = 1; reg_port = 2; reg_hi = 1; reg_wdata = 8'hE0;
    ig_valid = 1; ig_port = 2; ig_tagged = 0; ig_vid = 0; ig_prio = 0;
    eg_valid = 1; eg_port = 2; eg_insert = 1;
    @(negedge clk);
    reg_wr = 0; ig_valid = 0; eg_valid = 0;
    chk(ig_prio_o == 3'd0, "R11 ingress sees old tag", ig_prio_o, 0);
    chk(eg_tci_o == 16'h0001, "R11 egress sees old tag", eg_tci_o, 16'h0001);
    exp_tag[2][15:8] = 8'hE0;
    do_ig(2, 0, 0, 0);
    chk(ig_prio_o == 3'd7, "R11 next frame sees new tag", ig_prio_o, 7);
    do_eg(2, 1);
    chk(eg_tci_o == 16'hE001, "R11 egress new tag", eg_tci_o, 16'hE001);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    for (int p = 0; p < 3; p++) exp_tag[p] = 16'h0001;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_untagged();
    t_null_vid();
    t_tagged();
    t_no_insert();
    t_latency();
    t_port_indep();
    t_bad_port();
    t_same_cycle();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule